// File: doc/BRIEF.md
# Control-Word Driven Register-File Datapath

This block is the execution half of a small programmable engine. Each clock it takes one 20-bit control word and carries out one step. It reads two operands from an eight-entry register file and runs them through an arithmetic/logic unit. A shifter stage follows the ALU. The step may then write the result back into the register file, or write a value taken from an external input port instead. A registered output port shows the shifted result on the cycles where the control word asks for it.

The unit that issues the control words sits outside the block. Any routine is a list of words applied one per cycle: bit counting, accumulation, masking. The register file has no reset. Reset clears only the output register.

Top module: `rfdp_top`

## Requirements
- R1: While reset is high, and on the first cycle after reset falls, `out_data` is 0, whatever the control word carries.
- R2: The register file holds 8 words. With write enable set, the write-back value lands at the write address on the clock edge. A read of that address in the same cycle returns the old contents, and the new value is readable from the next cycle on.
- R3: A read port whose enable bit is 0 places 0 on its operand bus, whatever its address field holds.
- R4: Control bits 6:4 select the ALU function: 000 gives NOT A, 001 gives A AND B, 010 gives A XOR B, 011 gives A OR B, 100 gives A-1, 101 gives A+B, 110 gives A-B, and 111 gives A+1. Arithmetic wraps modulo 2^WIDTH.
- R5: Control bits 3:1 select the shifter function on the ALU result. Codes 000 to 011 pass the value unchanged. 100 shifts left with a 0 entering bit 0, and 101 rotates left. 110 shifts right with a 0 entering the top bit, and 111 rotates right.
- R6: With control bit 19 set, the write-back value is `in_data`. With bit 19 clear, it is the shifter result.
- R7: `out_data` is registered. After each edge it equals that cycle's shifter result when control bit 0 was 1, and 0 when bit 0 was 0.
- R8: The control word fields are placed as follows: bit 19 input select, bits 18:16 write address, bit 15 write enable, bits 14:12 port A address, bit 11 port A enable, bits 10:8 port B address, bit 7 port B enable, bits 6:4 ALU function, bits 3:1 shifter function, and bit 0 output enable. A multi-step routine built from these fields, such as counting the set bits of a loaded word, produces the correct result.
- R9: With write enable clear, no register changes, even when bit 19 selects `in_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears the output register |
| ctrl | input | 20 | Control word for the current cycle |
| in_data | input | WIDTH | External value that can be written back |
| out_data | output | WIDTH | Registered result, 0 when not enabled |

## Verification
The assertions take for granted that the control word and `in_data` are stable and free of unknowns around each rising edge. They also assume that a register is read only after it has been written, because the file is not reset. The stimulus meets the first condition by changing inputs only at falling edges. It meets the second by loading every register through the input port before any operation reads it. The scoreboard compares every cycle's output, so the no-write cases are caught when the untouched register is later brought out through the output port.

// File: rtl/rfdp_pkg.sv
package rfdp_pkg;

    localparam int CW_BITS   = 20;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [2:0] {
        ALU_NOT_A = 3'b000,
        ALU_AND   = 3'b001,
        ALU_XOR   = 3'b010,
        ALU_OR    = 3'b011,
        ALU_DEC_A = 3'b100,
        ALU_ADD   = 3'b101,
        ALU_SUB   = 3'b110,
        ALU_INC_A = 3'b111
    } alu_fn_e;

    typedef enum logic [2:0] {
        SHF_PASS0 = 3'b000,
        SHF_PASS1 = 3'b001,
        SHF_SPARE0 = 3'b010,
        SHF_SPARE1 = 3'b011,
        SHF_SHL   = 3'b100,
        SHF_ROL   = 3'b101,
        SHF_SHR   = 3'b110,
        SHF_ROR   = 3'b111
    } shf_fn_e;

    // Field order is fixed by the control-word layout (R8).
    typedef struct packed {
        logic                  src_ext;
        logic [REG_ADDR_W-1:0] wr_addr;
        logic                  wr_en;
        logic [REG_ADDR_W-1:0] a_addr;
        logic                  a_en;
        logic [REG_ADDR_W-1:0] b_addr;
        logic                  b_en;
        alu_fn_e               alu_fn;
        shf_fn_e               shf_fn;
        logic                  out_en;
    } ctrl_word_t;

endpackage

// File: rtl/rfdp_regfile.sv
module rfdp_regfile #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 3,
    parameter int NRD    = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [WIDTH-1:0]            wr_data,
    input  logic [NRD-1:0]              rd_en,
    input  logic [NRD-1:0][ADDR_W-1:0]  rd_addr,
    output logic [NRD-1:0][WIDTH-1:0]   rd_data
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    // Storage has no reset; only explicit writes change it.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = rd_en[p] ? mem[rd_addr[p]] : '0;
        end

        // R2
        wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(wr_en) && rd_en[p] && rd_addr[p] == $past(wr_addr))
            |-> rd_data[p] == $past(wr_data));

        // R3
        rd_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !rd_en[p] |-> rd_data[p] == '0);
    end

endmodule

// File: rtl/rfdp_alu.sv
module rfdp_alu
    import rfdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_fn_e           fn,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    output logic [WIDTH-1:0]  y
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (fn)
            ALU_NOT_A: y = ~a;
            ALU_AND:   y = a & b;
            ALU_XOR:   y = a ^ b;
            ALU_OR:    y = a | b;
            ALU_DEC_A: y = a - ONE;
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_INC_A: y = a + ONE;
            default:   y = '0;
        endcase
    end

    always_comb begin
        // R4
        if (fn == ALU_ADD) add_inverse_chk: assert (y - b == a);
        // R4
        if (fn == ALU_NOT_A) not_disjoint_chk: assert ((y & a) == '0);
    end

endmodule

// File: rtl/rfdp_shifter.sv
module rfdp_shifter
    import rfdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  shf_fn_e           fn,
    input  logic [WIDTH-1:0]  d,
    output logic [WIDTH-1:0]  y
);
    always_comb begin
        unique case (fn)
            SHF_SHL: y = {d[WIDTH-2:0], 1'b0};
            SHF_ROL: y = {d[WIDTH-2:0], d[WIDTH-1]};
            SHF_SHR: y = {1'b0, d[WIDTH-1:1]};
            SHF_ROR: y = {d[0], d[WIDTH-1:1]};
            default: y = d;
        endcase
    end

    always_comb begin
        // R5
        if (fn == SHF_ROL || fn == SHF_ROR)
            rotate_weight_chk: assert ($countones(y) == $countones(d));
    end

endmodule

// File: rtl/rfdp_top.sv
module rfdp_top
    import rfdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [19:0]        ctrl,
    input  logic [WIDTH-1:0]   in_data,
    output logic [WIDTH-1:0]   out_data
);
    localparam int NRD = 2;

    ctrl_word_t                      cw;
    logic [NRD-1:0]                  rd_en;
    logic [NRD-1:0][REG_ADDR_W-1:0]  rd_addr;
    logic [NRD-1:0][WIDTH-1:0]       rd_data;
    logic [WIDTH-1:0]                alu_y;
    logic [WIDTH-1:0]                result;
    logic [WIDTH-1:0]                wb_data;
    logic [WIDTH-1:0]                out_q;

    assign cw      = ctrl_word_t'(ctrl);
    assign rd_en   = {cw.b_en, cw.a_en};
    assign rd_addr = {cw.b_addr, cw.a_addr};
    assign wb_data = cw.src_ext ? in_data : result;

    rfdp_regfile #(.WIDTH(WIDTH), .ADDR_W(REG_ADDR_W), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cw.wr_en),
        .wr_addr (cw.wr_addr),
        .wr_data (wb_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rfdp_alu #(.WIDTH(WIDTH)) u_alu (
        .fn (cw.alu_fn),
        .a  (rd_data[0]),
        .b  (rd_data[1]),
        .y  (alu_y)
    );

    rfdp_shifter #(.WIDTH(WIDTH)) u_shf (
        .fn (cw.shf_fn),
        .d  (alu_y),
        .y  (result)
    );

    always_ff @(posedge clk) begin
        if (rst)            out_q <= '0;
        else if (cw.out_en) out_q <= result;
        else                out_q <= '0;
    end

    assign out_data = out_q;

    // R7
    out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cw.out_en) |-> out_data == '0);

    // R7
    out_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cw.out_en) && !$past(rst)) |-> out_data == $past(result));

    // R1
    out_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> out_data == '0);

endmodule

// File: tb/tb_rfdp_top.sv
module tb_rfdp_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [19:0]  ctrl;
    logic [W-1:0] din;
    logic [W-1:0] dout;

    always #5 clk = ~clk;

    rfdp_top #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .ctrl(ctrl), .in_data(din), .out_data(dout)
    );

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } sb_item_t;

    sb_item_t     sbq[$];
    int           nvec = 0;
    int           nbad = 0;
    bit           done = 0;
    logic [W-1:0] model [8];

    function automatic logic [19:0] mk(bit ie, int wa, bit we, int ra, bit rea,
                                       int rb, bit reb, int alu, int shf, bit oe);
        return {ie, 3'(wa), we, 3'(ra), rea, 3'(rb), reb, 3'(alu), 3'(shf), oe};
    endfunction

    function automatic logic [W-1:0] ref_alu(int f, logic [W-1:0] a, logic [W-1:0] b);
        case (f)
            0: return ~a;
            1: return a & b;
            2: return a ^ b;
            3: return a | b;
            4: return W'(a + {W{1'b1}});
            5: return W'(a + b);
            6: return W'(a + ~b + 1'b1);
            default: return W'(a + 1'b1);
        endcase
    endfunction

    function automatic logic [W-1:0] ref_shf(int f, logic [W-1:0] v);
        logic [2*W-1:0] dbl;
        dbl = {v, v};
        case (f)
            4: return v << 1;
            5: return dbl[2*W-2 -: W];
            6: return v >> 1;
            7: return dbl[W -: W];
            default: return v;
        endcase
    endfunction

    task automatic drive(logic [19:0] cw, logic [W-1:0] d, string tag);
        logic [W-1:0] a, b, res;
        sb_item_t     it;
        @(negedge clk);
        ctrl = cw;
        din  = d;
        a   = cw[11] ? model[cw[14:12]] : '0;
        b   = cw[7]  ? model[cw[10:8]]  : '0;
        res = ref_shf(int'(cw[3:1]), ref_alu(int'(cw[6:4]), a, b));
        it.exp = cw[0] ? res : '0;
        it.tag = tag;
        sbq.push_back(it);
        if (cw[15]) model[cw[18:16]] = cw[19] ? d : res;
    endtask

    // Monitor: compare each cycle's output just after the edge
    initial begin
        sb_item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                nvec++;
                if (dout !== it.exp) begin
                    nbad++;
                    $display("FAIL %s: out_data=%h expected %h", it.tag, dout, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] vals [8];
        vals = '{8'h00, 8'h5A, 8'h3C, 8'h81, 8'h96, 8'h01, 8'h7F, 8'hFF};
        rst  = 1'b1;
        ctrl = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);   // oe high during reset
        din  = '0;
        repeat (2) @(posedge clk);
        #1;
        nvec++;
        if (dout !== '0) begin nbad++; $display("FAIL R1: out_data=%h expected 00 in reset", dout); end
        @(negedge clk);
        rst = 1'b0;
        ctrl = '0;
        @(posedge clk); #1;
        nvec++;
        if (dout !== '0) begin nbad++; $display("FAIL R1: out_data=%h expected 00 after reset", dout); end

        // R6: load every register from the input port
        for (int i = 0; i < 8; i++) drive(mk(1, i, 1, 0, 0, 0, 0, 3, 0, 1), vals[i], "R6 load");

        // R4: each ALU function on r1/r2, then wrap corners
        for (int f = 0; f < 8; f++) drive(mk(0, 0, 0, 1, 1, 2, 1, f, 0, 1), '0, "R4 alu r1,r2");
        drive(mk(0, 0, 0, 0, 1, 0, 0, 4, 0, 1), '0, "R4 decrement 00 wraps");
        drive(mk(0, 0, 0, 7, 1, 0, 0, 7, 0, 1), '0, "R4 increment FF wraps");
        drive(mk(0, 0, 0, 2, 1, 1, 1, 6, 0, 1), '0, "R4 subtract borrows");
        drive(mk(0, 0, 0, 6, 1, 5, 1, 5, 0, 1), '0, "R4 add 7F+01");

        // R5: every shifter code on two patterns
        for (int s = 0; s < 8; s++) begin
            drive(mk(0, 0, 0, 3, 1, 0, 0, 3, s, 1), '0, "R5 shift 81");
            drive(mk(0, 0, 0, 4, 1, 0, 0, 3, s, 1), '0, "R5 shift 96");
        end

        // R3: disabled ports read 0 regardless of address
        drive(mk(0, 0, 0, 7, 0, 2, 1, 3, 0, 1), '0, "R3 port A off");
        drive(mk(0, 0, 0, 1, 1, 7, 0, 3, 0, 1), '0, "R3 port B off");
        drive(mk(0, 0, 0, 7, 0, 7, 0, 0, 0, 1), '0, "R3 both off");

        // R6: shifter result written back, then read
        drive(mk(0, 4, 1, 1, 1, 2, 1, 5, 4, 1), '0, "R6 write-back shifter");
        drive(mk(0, 0, 0, 4, 1, 0, 0, 3, 0, 1), '0, "R6 readback");

        // R2: same-cycle read sees old value, next cycle sees new
        drive(mk(1, 5, 1, 5, 1, 0, 0, 3, 0, 1), 8'hC3, "R2 same-cycle old");
        drive(mk(0, 0, 0, 5, 1, 0, 0, 3, 0, 1), '0, "R2 next-cycle new");

        // R9: write enable clear leaves register unchanged
        drive(mk(1, 6, 0, 0, 0, 0, 0, 3, 0, 1), 8'hEE, "R9 no write");
        drive(mk(0, 0, 0, 6, 1, 0, 0, 3, 0, 1), '0, "R9 readback");

        // R7: output gated off
        drive(mk(0, 0, 0, 7, 1, 0, 0, 3, 0, 0), '0, "R7 oe low");
        drive(mk(0, 0, 0, 7, 1, 0, 0, 3, 0, 1), '0, "R7 oe high");
        drive(mk(0, 0, 0, 7, 1, 0, 0, 3, 0, 0), '0, "R7 oe low again");

        // R8: set-bit count of 0xB5 (expect 5) and 0xFF (expect 8)
        for (int k = 0; k < 2; k++) begin
            drive(mk(1, 1, 1, 0, 0, 0, 0, 3, 0, 0), (k == 0) ? 8'hB5 : 8'hFF, "R8 data in");
            drive(mk(0, 3, 1, 0, 0, 0, 0, 1, 0, 0), '0, "R8 clear count");
            drive(mk(0, 2, 1, 0, 0, 0, 0, 7, 0, 0), '0, "R8 mask one");
            for (int it = 0; it < W; it++) begin
                drive(mk(0, 4, 1, 1, 1, 2, 1, 1, 0, 0), '0, "R8 temp");
                drive(mk(0, 3, 1, 3, 1, 4, 1, 5, 0, 0), '0, "R8 accumulate");
                drive(mk(0, 1, 1, 1, 1, 0, 0, 3, 6, 0), '0, "R8 shift data");
            end
            drive(mk(0, 0, 0, 3, 1, 0, 0, 3, 0, 1), '0, "R8 count out");
        end
        if (model[3] !== 8'd8) begin
            nbad++;
            $display("FAIL R8: reference count %0d expected 8", model[3]);
        end

        drive('0, '0, "R7 idle");
        @(posedge clk); #2;
        @(posedge clk); #2;
        done = 1;
        finish_run();
    end

endmodule